// File: doc/BRIEF.md
# Cascadable Dual-Stage Compare Timer

This block is a programmable interval timer made of a narrow low stage (4 bits by default) and a wider high stage (8 bits by default). Each stage has its own compare value. A mode field arranges the two stages in one of three ways:
- **Chained:** they act as one wide counter.
- **Prescaled:** the low stage divides the count clock for the high stage.
- **Split:** the low stage runs as a free prescaler while the high stage counts the same input directly.

A five-bit action mask decides what a compare match or an overflow of the main counter does. A match can clear the counter, flip the toggle output or raise an interrupt pulse. An overflow can flip the toggle output or raise an interrupt pulse.

The block counts enable pulses, not clock edges. Four sources arrive as single-cycle strobes in the system clock domain, and a two-bit field picks one of them. A small write port loads the configuration, the two compare values and the action mask. Every output is a register. The low stage also drives a strobe each time it rolls back to zero, so it can serve as a divided clock for logic nearby.

Top module: `dst_timer`

## Requirements
- R1: Synchronous active-high reset clears the counters, the configuration (source 00, chained mode), both compare values and the mask, and drives `tog_out`, `pre_out` and `irq` low.
- R2: Configuration bits [1:0] select the count source: 00 = `tick_sys`, 01 = `tick_ext`, 10 = `tick_tmr`, 11 = `tick_shf`. Strobes on the sources that are not selected do not advance anything.
- R3: In chained mode (configuration bits [3:2] = 00) the two stages form one 12-bit counter whose match value is {high compare, low compare}. With match-clear set, the interval is that value plus one strobes, from 1 to 4096.
- R4: In prescaled mode (bits [3:2] = 01) the high stage advances once per (low compare + 1) strobes. The match interval is therefore (low compare + 1) × (high compare + 1) strobes.
- R5: In split mode (bits [3:2] = 10 or 11) the high stage advances on every strobe, with a match interval of high compare + 1 (1 to 256). The low stage independently repeats every low compare + 1 strobes (1 to 16).
- R6: `pre_out` is high for one cycle after each counted strobe that returns the low stage to zero. In chained mode this happens at its carry out of 15 or at a match-clear.
- R7: Mask bit 0 enables clear on match, bit 1 enables toggle on match and bit 2 enables interrupt on match. Each acts only on a counted step of the main counter whose value equals the compare value.
- R8: With mask bit 0 clear, the main counter runs on through its compare value to all ones and wraps to zero. Mask bit 3 toggles `tog_out` and mask bit 4 pulses `irq` on that overflow step.
- R9: Any write cycle suspends counting and produces no event. Register addresses are 0 = configuration, 1 = low compare, 2 = high compare, 3 = mask. Writing address 1 clears the low stage, address 2 clears the high stage, and address 0 clears both.
- R10: Outputs are registered. `irq` and `pre_out` are high only in the cycle after a counted strobe that caused the event, and `tog_out` changes only then. A toggle request from a match and an overflow on the same step flips the output once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sys | input | 1 | Count strobe from the system clock divider |
| tick_ext | input | 1 | Count strobe from the external input, already synchronised |
| tick_tmr | input | 1 | Count strobe from a neighbouring timer |
| tick_shf | input | 1 | Count strobe from the serial shift clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| tog_out | output | 1 | Toggle output |
| pre_out | output | 1 | One-cycle strobe when the low stage rolls over |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench checks the carry from the low stage into the high stage in chained mode. A design that compared only one stage, or left the high stage uncleared on a match, would show wrong intervals and extra `pre_out` strobes. It checks the prescaled interval product and the source-select encoding, where a swapped mux leg would count a strobe that should be ignored. It checks that a compare write clears its stage even when a strobe arrives in the same cycle, where a counter that kept counting would interrupt early. It also checks that an unmasked-clear counter runs past its match to the all-ones overflow, where a design that wrapped at the compare value would toggle or interrupt far too often.

// File: rtl/dst_pkg.sv
package dst_pkg;

  typedef enum logic [1:0] {
    MODE_CHAIN    = 2'b00,
    MODE_PRESCALE = 2'b01,
    MODE_SPLIT    = 2'b10,
    MODE_SPLIT_B  = 2'b11
  } mode_e;

  // action mask, bit 0 at the bottom
  typedef struct packed {
    logic ovf_irq;  // bit 4
    logic ovf_tog;  // bit 3
    logic hit_irq;  // bit 2
    logic hit_tog;  // bit 1
    logic hit_rst;  // bit 0
  } act_mask_t;

  localparam int MASK_W   = 5;
  localparam int SEL_W    = 2;
  localparam int N_SRC    = 4;
  localparam int ADDR_CFG = 0;
  localparam int ADDR_LO  = 1;
  localparam int ADDR_HI  = 2;
  localparam int ADDR_MSK = 3;

endpackage

// File: rtl/dst_regs.sv
module dst_regs
  import dst_pkg::*;
#(
  parameter int LO_W   = 4,
  parameter int HI_W   = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  clk_sel,
  output mode_e             mode,
  output logic [LO_W-1:0]   cmp_lo,
  output logic [HI_W-1:0]   cmp_hi,
  output act_mask_t         mask,
  output logic              clr_lo,
  output logic              clr_hi
);

  logic sel_cfg, sel_lo, sel_hi, sel_msk;

  always_comb begin
    sel_cfg = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
    sel_lo  = wr_en && (wr_addr == ADDR_W'(ADDR_LO));
    sel_hi  = wr_en && (wr_addr == ADDR_W'(ADDR_HI));
    sel_msk = wr_en && (wr_addr == ADDR_W'(ADDR_MSK));
    clr_lo  = sel_cfg || sel_lo;
    clr_hi  = sel_cfg || sel_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sel <= '0;
      mode    <= MODE_CHAIN;
      cmp_lo  <= '0;
      cmp_hi  <= '0;
      mask    <= '0;
    end else begin
      if (sel_cfg) begin
        clk_sel <= wr_data[SEL_W-1:0];
        mode    <= mode_e'(wr_data[SEL_W+1:SEL_W]);
      end
      if (sel_lo)  cmp_lo <= wr_data[LO_W-1:0];
      if (sel_hi)  cmp_hi <= wr_data[HI_W-1:0];
      if (sel_msk) mask   <= act_mask_t'(wr_data[MASK_W-1:0]);
    end
  end

endmodule

// File: rtl/dst_clksel.sv
module dst_clksel #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  src,
  input  logic [SW-1:0] sel,
  output logic          tick
);

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) tick = src[i];
    end
  end

endmodule

// File: rtl/dst_stage.sv
module dst_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         zero_req,
  output logic [W-1:0] count,
  output logic         at_max
);

  assign at_max = &count;

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (step)   count <= zero_req ? '0 : count + W'(1);
  end

endmodule

// File: rtl/dst_action.sv
module dst_action
  import dst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_step,
  input  logic      ev_hit,
  input  logic      ev_ovf,
  input  logic      pre_evt,
  input  act_mask_t mask,
  output logic      tog_out,
  output logic      pre_out,
  output logic      irq
);

  logic want_tog, want_irq;

  always_comb begin
    want_tog = ev_step && ((ev_hit && mask.hit_tog) || (ev_ovf && mask.ovf_tog));
    want_irq = ev_step && ((ev_hit && mask.hit_irq) || (ev_ovf && mask.ovf_irq));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_out <= 1'b0;
      pre_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tog_out <= tog_out ^ want_tog;
      pre_out <= pre_evt;
      irq     <= want_irq;
    end
  end

endmodule

// File: rtl/dst_timer.sv
module dst_timer
  import dst_pkg::*;
#(
  parameter int LO_W   = 4,
  parameter int HI_W   = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_sys,
  input  logic              tick_ext,
  input  logic              tick_tmr,
  input  logic              tick_shf,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tog_out,
  output logic              pre_out,
  output logic              irq
);

  localparam int FULL_W = LO_W + HI_W;

  logic [SEL_W-1:0] clk_sel;
  mode_e            mode;
  logic [LO_W-1:0]  cmp_lo, c_lo;
  logic [HI_W-1:0]  cmp_hi, c_hi;
  act_mask_t        mask;
  logic             clr_lo, clr_hi;
  logic             tick, run;
  logic             lo_max, hi_max;
  logic             lo_hit, hi_hit, full_hit, full_ovf;
  logic             lo_step, lo_zero, hi_step, hi_zero;
  logic             ev_step, ev_hit, ev_ovf, pre_evt;
  logic [FULL_W-1:0] full_cnt, full_cmp;

  dst_regs #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_sel(clk_sel), .mode(mode), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .mask(mask), .clr_lo(clr_lo), .clr_hi(clr_hi)
  );

  dst_clksel #(.N(N_SRC)) u_sel (
    .src({tick_shf, tick_tmr, tick_ext, tick_sys}),
    .sel(clk_sel),
    .tick(tick)
  );

  dst_stage #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .clr(clr_lo), .step(lo_step), .zero_req(lo_zero),
    .count(c_lo), .at_max(lo_max)
  );

  dst_stage #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .clr(clr_hi), .step(hi_step), .zero_req(hi_zero),
    .count(c_hi), .at_max(hi_max)
  );

  always_comb begin
    run      = tick && !wr_en;
    full_cnt = {c_hi, c_lo};
    full_cmp = {cmp_hi, cmp_lo};
    full_hit = (full_cnt == full_cmp);
    full_ovf = lo_max && hi_max;
    lo_hit   = (c_lo == cmp_lo);
    hi_hit   = (c_hi == cmp_hi);
    lo_step  = run;
    case (mode)
      MODE_CHAIN: begin
        lo_zero = full_hit && mask.hit_rst;
        hi_step = run && (lo_max || lo_zero);
        hi_zero = lo_zero;
        ev_step = run;
        ev_hit  = full_hit;
        ev_ovf  = full_ovf;
      end
      MODE_PRESCALE: begin
        lo_zero = lo_hit;
        hi_step = run && lo_hit;
        hi_zero = hi_hit && mask.hit_rst;
        ev_step = hi_step;
        ev_hit  = hi_hit;
        ev_ovf  = hi_max;
      end
      default: begin
        lo_zero = lo_hit;
        hi_step = run;
        hi_zero = hi_hit && mask.hit_rst;
        ev_step = run;
        ev_hit  = hi_hit;
        ev_ovf  = hi_max;
      end
    endcase
    pre_evt = lo_step && (lo_zero || lo_max);
  end

  dst_action u_act (
    .clk(clk), .rst(rst), .ev_step(ev_step), .ev_hit(ev_hit), .ev_ovf(ev_ovf),
    .pre_evt(pre_evt), .mask(mask), .tog_out(tog_out), .pre_out(pre_out), .irq(irq)
  );

endmodule

// File: rtl/dst_checker.sv
module dst_checker #(
  parameter int LO_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            tick,
  input logic            irq,
  input logic            tog_out,
  input logic            pre_out,
  input logic [1:0]      mode,
  input logic [LO_W-1:0] c_lo,
  input logic [LO_W-1:0] cmp_lo
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !pre_out && !tog_out));

  // R9
  write_suspends_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!irq && !pre_out && $stable(tog_out)));

  // R10
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(tick) && !$past(wr_en)));

  // R6
  pre_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pre_out |-> $past(tick));

  // R2
  idle_holds_tog_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tog_out));

  // R5
  lo_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00) |-> (c_lo <= cmp_lo));

endmodule

bind dst_timer dst_checker #(.LO_W(LO_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tick(tick), .irq(irq),
  .tog_out(tog_out), .pre_out(pre_out), .mode(mode), .c_lo(c_lo), .cmp_lo(cmp_lo)
);

// File: tb/dst_timer_tb.sv
`timescale 1ns/1ps
module dst_timer_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_sys = 1'b0, tick_ext = 1'b0, tick_tmr = 1'b0, tick_shf = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tog_out, pre_out, irq;

  always #2.5 clk = ~clk;

  dst_timer u_dut (
    .clk(clk), .rst(rst), .tick_sys(tick_sys), .tick_ext(tick_ext),
    .tick_tmr(tick_tmr), .tick_shf(tick_shf), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tog_out(tog_out), .pre_out(pre_out), .irq(irq)
  );

  int checks = 0, errors = 0;
  int n_irq = 0, n_pre = 0, n_tog = 0;
  logic tog_prev = 1'b0;
  logic started = 1'b0;
  bit done = 0;

  // behavioural reference state
  int m_sel = 0, m_mode = 0, m_clo = 0, m_chi = 0, m_mask = 0;
  int m_lo = 0, m_hi = 0;
  logic m_tog = 0, m_irq = 0, m_pre = 0;

  always @(posedge clk) begin
    int srcs [4];
    int v, full, nv, nlo, nhi;
    bit t, hit, ov, ev, adv, lw;
    srcs[0] = tick_sys; srcs[1] = tick_ext; srcs[2] = tick_tmr; srcs[3] = tick_shf;
    started <= 1'b1;
    if (rst) begin
      m_sel = 0; m_mode = 0; m_clo = 0; m_chi = 0; m_mask = 0;
      m_lo = 0; m_hi = 0; m_tog = 0; m_irq = 0; m_pre = 0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin m_sel = wr_data & 3; m_mode = (wr_data >> 2) & 3; m_lo = 0; m_hi = 0; end
        2'd1: begin m_clo = wr_data & 15; m_lo = 0; end
        2'd2: begin m_chi = wr_data; m_hi = 0; end
        default: m_mask = wr_data & 31;
      endcase
      m_irq = 0; m_pre = 0;
    end else begin
      t = (srcs[m_sel] != 0);
      m_irq = 0; m_pre = 0; ev = 0; hit = 0; ov = 0;
      if (t) begin
        if (m_mode == 0) begin
          v = m_hi * 16 + m_lo;
          full = m_chi * 16 + m_clo;
          hit = (v == full);
          ov = (v == 4095);
          nv = (hit && m_mask[0]) ? 0 : (v + 1) % 4096;
          m_pre = (nv % 16 == 0);
          m_lo = nv % 16; m_hi = nv / 16;
          ev = 1;
        end else begin
          lw = (m_lo == m_clo);
          nlo = lw ? 0 : m_lo + 1;
          m_pre = lw;
          adv = (m_mode == 1) ? lw : 1;
          if (adv) begin
            hit = (m_hi == m_chi);
            ov = (m_hi == 255);
            nhi = (hit && m_mask[0]) ? 0 : (m_hi + 1) % 256;
            m_hi = nhi;
            ev = 1;
          end
          m_lo = nlo;
        end
        if (ev) begin
          if ((hit && m_mask[1]) || (ov && m_mask[3])) m_tog = ~m_tog;
          m_irq = (hit && m_mask[2]) || (ov && m_mask[4]);
        end
      end
    end
  end

  // R10: outputs compared with the reference on every cycle
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (irq !== m_irq || pre_out !== m_pre || tog_out !== m_tog) begin
        errors++;
        $display("FAIL R10 cycle compare at %0t: irq/pre/tog=%b%b%b expected %b%b%b",
                 $time, irq, pre_out, tog_out, m_irq, m_pre, m_tog);
      end
      if (!rst) begin
        if (irq) n_irq++;
        if (pre_out) n_pre++;
        if (tog_out !== tog_prev) n_tog++;
      end
      tog_prev = tog_out;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic setup(input int cfg, input int lo, input int hi, input int msk);
    wr(0, cfg); wr(1, lo); wr(2, hi); wr(3, msk);
  endtask

  task automatic zero_counts();
    @(posedge clk); #1;
    n_irq = 0; n_pre = 0; n_tog = 0;
  endtask

  task automatic run(input int n, input logic [3:0] src, input int every);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      {tick_shf, tick_tmr, tick_ext, tick_sys} = (i % every == 0) ? src : 4'b0000;
    end
    @(posedge clk); #1;
    {tick_shf, tick_tmr, tick_ext, tick_sys} = 4'b0000;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 pre_out after reset", pre_out, 0);
    check("R1 tog_out after reset", tog_out, 0);
    @(posedge clk); #1; rst = 1'b0;

    // R1: reset values give chained mode, compare 0, mask 0: no irq, pre per 16 strobes
    zero_counts();
    run(32, 4'b0001, 1);
    check("R1 default irq", n_irq, 0);
    check("R1 default pre", n_pre, 2);

    // R3 / R7: chained, match at 0x13, clear+toggle+irq
    setup(8'h00, 3, 1, 8'h07);
    zero_counts();
    run(100, 4'b0001, 1);
    check("R3 chained irq", n_irq, 5);
    check("R7 chained toggles", n_tog, 5);
    check("R6 chained pre", n_pre, 10);

    // R4: prescaled, interval 3*4
    setup(8'h04, 2, 3, 8'h05);
    zero_counts();
    run(120, 4'b0001, 1);
    check("R4 prescaled irq", n_irq, 10);
    check("R6 prescaled pre", n_pre, 40);

    // R5: split, high every 10, low every 5
    setup(8'h08, 4, 9, 8'h05);
    zero_counts();
    run(100, 4'b0001, 1);
    check("R5 split irq", n_irq, 10);
    check("R5 split pre", n_pre, 20);

    // R2: each source select, other sources ignored
    setup(8'h08, 0, 4, 8'h05);
    for (int s = 0; s < 4; s++) begin
      wr(0, 8'h08 | s);
      zero_counts();
      run(30, ~(4'b0001 << s), 1);
      check($sformatf("R2 unselected sources sel=%0d", s), n_irq + n_pre, 0);
      zero_counts();
      run(50, 4'b0001 << s, 2);
      check($sformatf("R2 selected source sel=%0d", s), n_irq, 5);
    end

    // R7: toggle only, no interrupt
    setup(8'h08, 0, 3, 8'h03);
    zero_counts();
    run(40, 4'b0001, 1);
    check("R7 toggle-only toggles", n_tog, 10);
    check("R7 toggle-only irq", n_irq, 0);

    // R8: no clear on match: run to all ones
    setup(8'h08, 0, 5, 8'h12);
    zero_counts();
    run(512, 4'b0001, 1);
    check("R8 overflow irq", n_irq, 2);
    check("R8 match toggles without clear", n_tog, 2);

    // R8: chained overflow at 4095
    setup(8'h00, 0, 0, 8'h18);
    zero_counts();
    run(4096, 4'b0001, 1);
    check("R8 chained overflow irq", n_irq, 1);
    check("R8 chained overflow toggles", n_tog, 1);

    // R9: compare write clears stage and ignores a strobe in the same cycle
    setup(8'h08, 0, 9, 8'h05);
    zero_counts();
    run(7, 4'b0001, 1);
    @(posedge clk); #1;
    tick_sys = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd9;
    @(posedge clk); #1;
    wr_en = 1'b0; tick_sys = 1'b0;
    run(9, 4'b0001, 1);
    check("R9 cleared count no early irq", n_irq, 0);
    run(1, 4'b0001, 1);
    check("R9 irq after full interval", n_irq, 1);

    // R10: single event gives single-cycle irq; back-to-back events
    setup(8'h08, 0, 0, 8'h05);
    zero_counts();
    run(1, 4'b0001, 1);
    check("R10 one strobe one irq cycle", n_irq, 1);
    zero_counts();
    run(4, 4'b0001, 1);
    check("R10 consecutive events", n_irq, 4);

    // R10: match and overflow on same step flip the toggle once
    setup(8'h08, 0, 255, 8'h1B);
    zero_counts();
    run(512, 4'b0001, 1);
    check("R10 coincident toggle", n_tog, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule